// File: doc/BRIEF.md
# Masked Vector Bitwise OR Unit

This block is the logical-OR execution slice of a vector datapath whose register file is up to 512 bits wide. Each accepted operation combines two source vectors bit by bit, and then decides, 32-bit chunk by 32-bit chunk, which value each part of the destination receives: the OR result, the previous destination contents, or zero. The choice depends on the operating mode, the vector length, the element size and a per-element write mask.

Four modes are supported:
- a 64-bit scalar-register mode;
- a 128-bit legacy mode that leaves the upper destination bits untouched;
- a zero-upper mode at 128 or 256 bits;
- a masked mode at 128, 256 or 512 bits, with merging or zeroing of masked-off elements.

In masked mode, a memory-sourced second operand can be broadcast: its lowest element is applied to every lane. The result, an error strobe and a valid strobe are registered and appear one clock after the operation is presented. Instruction decode, memory access and register storage sit outside this block.

Top module: `simd_or_unit`

## Requirements
- R1: Mode code 0 (scalar) gives `result[63:0] = dst_old[63:0] | src2[63:0]`. Bits 511:64 equal `dst_old`. `src1` is not used. Each result bit is 1 exactly when either operand bit is 1.
- R2: Mode code 1 (legacy) gives `result[127:0] = dst_old[127:0] | src2[127:0]`. Bits 511:128 equal `dst_old`.
- R3: Mode code 2 (zero-upper) reads `vlen`: code 0 means 128 bits and code 1 means 256 bits. The low `vlen` bits become `src1 | src2`. Every bit above that length is 0.
- R4: Mode code 3 (masked) reads `vlen`: 0, 1 and 2 mean 128, 256 and 512 bits. `esz64` = 0 selects 32-bit elements and 1 selects 64-bit elements. Element j occupies bits j·width upward. Element j takes `src1 | src2` when `kmask[j]` is 1, or when `mask_en` is 0.
- R5: In masked mode, an element whose mask bit is 0 while `mask_en` is 1 is handled by `zero_mask`. With `zero_mask` = 0 the element keeps `dst_old`. With `zero_mask` = 1 it becomes all zeros.
- R6: In masked mode with `bcast` = 1 and `src2_mem` = 1, every element is ORed with the lowest element of `src2`. That element is `src2[31:0]` for 32-bit elements and `src2[63:0]` for 64-bit elements.
- R7: With `bcast` = 1 and `src2_mem` = 0, the broadcast request has no effect and the OR is done lane by lane.
- R8: In masked mode, every bit at or above the active vector length is 0, whatever the mask and `zero_mask` say.
- R9: Mask bits at or above the element count of the active length and element size have no effect on the result.
- R10: `out_valid` is 1 exactly one clock after a cycle with `in_valid` = 1, and 0 otherwise. A synchronous `rst` clears `out_valid` and `err`.
- R11: Some encodings are unused: mode codes 4 to 7, `vlen` code 3 in masked mode, and `vlen` codes 2 or 3 in zero-upper mode. For an unused encoding, `result` equals `dst_old` and `err` is 1 together with `out_valid`. Otherwise `err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| mode | input | 3 | Operating mode code |
| vlen | input | 2 | Vector length code |
| esz64 | input | 1 | Element size: 0 = 32 bits, 1 = 64 bits |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value |
| kmask | input | 16 | Per-element write mask |
| mask_en | input | 1 | Write masking in force |
| zero_mask | input | 1 | Masked-off elements become zero instead of merging |
| bcast | input | 1 | Broadcast request for the second operand |
| src2_mem | input | 1 | Second operand was fetched from memory |
| out_valid | output | 1 | Result valid |
| result | output | 512 | New destination value |
| err | output | 1 | Unused encoding was presented |

## Verification
Faults in this block are visible in the very next output cycle, because the only state it holds is the output register. A wrong per-chunk selection shows up as a 32-bit or 64-bit slice that carries stale destination data, stray zeros or OR data where another value belongs. Typical examples are a slice past the vector length, or an element whose mask bit points the other way. A wrong broadcast or mask-index mapping corrupts whole elements in a pattern that follows the element size. The bench therefore compares the full 512-bit word and the error flag on every valid cycle, against a bit-level model written straight from the requirements.

// File: rtl/simd_or_pkg.sv
package simd_or_pkg;

    localparam int MAXW    = 512;
    localparam int CHUNK   = 32;
    localparam int NCHUNK  = MAXW / CHUNK;
    localparam int KW      = 16;
    localparam int LIMW    = $clog2(NCHUNK) + 1;

    typedef enum logic [2:0] {
        OP_SCALAR64  = 3'd0,
        OP_LEGACY128 = 3'd1,
        OP_ZEROUP    = 3'd2,
        OP_MASKED    = 3'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        SEL_OR   = 2'd0,
        SEL_OLD  = 2'd1,
        SEL_ZERO = 2'd2
    } chunk_sel_e;

    typedef struct packed {
        logic             legal;
        logic             a_is_dst;
        logic [LIMW-1:0]  lim;
        chunk_sel_e       upper_sel;
        logic             masked;
        logic             mask_en;
        logic             zero_mask;
        logic             esz64;
        logic             bcast_on;
    } or_ctrl_t;

    // Number of 32-bit chunks covered by a vector length code (0 = unused).
    function automatic logic [LIMW-1:0] vlen_chunks(input logic [1:0] v);
        case (v)
            2'd0:    return LIMW'(128 / CHUNK);
            2'd1:    return LIMW'(256 / CHUNK);
            2'd2:    return LIMW'(512 / CHUNK);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/simd_or_decode.sv
module simd_or_decode
    import simd_or_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] vlen,
    input  logic       esz64,
    input  logic       mask_en,
    input  logic       zero_mask,
    input  logic       bcast,
    input  logic       src2_mem,
    output or_ctrl_t   ctrl
);
    always_comb begin
        ctrl           = '0;
        ctrl.upper_sel = SEL_OLD;
        ctrl.esz64     = esz64;
        case (mode)
            OP_SCALAR64: begin
                ctrl.legal    = 1'b1;
                ctrl.a_is_dst = 1'b1;
                ctrl.lim      = LIMW'(64 / CHUNK);
            end
            OP_LEGACY128: begin
                ctrl.legal    = 1'b1;
                ctrl.a_is_dst = 1'b1;
                ctrl.lim      = LIMW'(128 / CHUNK);
            end
            OP_ZEROUP: begin
                ctrl.legal     = (vlen == 2'd0) || (vlen == 2'd1);
                ctrl.lim       = vlen_chunks(vlen);
                ctrl.upper_sel = SEL_ZERO;
            end
            OP_MASKED: begin
                ctrl.legal     = (vlen != 2'd3);
                ctrl.lim       = vlen_chunks(vlen);
                ctrl.upper_sel = SEL_ZERO;
                ctrl.masked    = 1'b1;
                ctrl.mask_en   = mask_en;
                ctrl.zero_mask = zero_mask;
                ctrl.bcast_on  = bcast && src2_mem;
            end
            default: ctrl.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/simd_or_bcast.sv
module simd_or_bcast
    import simd_or_pkg::*;
(
    input  or_ctrl_t          ctrl,
    input  logic [MAXW-1:0]   src2,
    output logic [MAXW-1:0]   src2_eff
);
    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        localparam int PAIR = (c % 2) * CHUNK;
        logic [CHUNK-1:0] rep;
        always_comb begin
            rep = ctrl.esz64 ? src2[PAIR +: CHUNK] : src2[CHUNK-1:0];
            src2_eff[c*CHUNK +: CHUNK] = ctrl.bcast_on ? rep : src2[c*CHUNK +: CHUNK];
        end
    end
endmodule

// File: rtl/simd_or_lanes.sv
module simd_or_lanes
    import simd_or_pkg::*;
(
    input  or_ctrl_t          ctrl,
    input  logic [MAXW-1:0]   opa,
    input  logic [MAXW-1:0]   opb,
    input  logic [MAXW-1:0]   dst_old,
    input  logic [KW-1:0]     kmask,
    output logic [MAXW-1:0]   res
);
    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        localparam logic [LIMW-1:0] CIDX = LIMW'(c);
        localparam int KI32 = c;
        localparam int KI64 = c / 2;
        chunk_sel_e sel;
        logic       kbit;
        always_comb begin
            kbit = ctrl.esz64 ? kmask[KI64] : kmask[KI32];
            if (!ctrl.legal)
                sel = SEL_OLD;
            else if (CIDX >= ctrl.lim)
                sel = ctrl.upper_sel;
            else if (!ctrl.masked || !ctrl.mask_en || kbit)
                sel = SEL_OR;
            else
                sel = ctrl.zero_mask ? SEL_ZERO : SEL_OLD;
            case (sel)
                SEL_OR:  res[c*CHUNK +: CHUNK] = opa[c*CHUNK +: CHUNK] | opb[c*CHUNK +: CHUNK];
                SEL_OLD: res[c*CHUNK +: CHUNK] = dst_old[c*CHUNK +: CHUNK];
                default: res[c*CHUNK +: CHUNK] = '0;
            endcase
        end
    end
endmodule

// File: rtl/simd_or_unit.sv
module simd_or_unit
    import simd_or_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        mode,
    input  logic [1:0]        vlen,
    input  logic              esz64,
    input  logic [MAXW-1:0]   src1,
    input  logic [MAXW-1:0]   src2,
    input  logic [MAXW-1:0]   dst_old,
    input  logic [KW-1:0]     kmask,
    input  logic              mask_en,
    input  logic              zero_mask,
    input  logic              bcast,
    input  logic              src2_mem,
    output logic              out_valid,
    output logic [MAXW-1:0]   result,
    output logic              err
);
    or_ctrl_t        ctrl;
    logic [MAXW-1:0] src2_eff;
    logic [MAXW-1:0] opa;
    logic [MAXW-1:0] res_c;

    simd_or_decode u_dec (
        .mode      (mode),
        .vlen      (vlen),
        .esz64     (esz64),
        .mask_en   (mask_en),
        .zero_mask (zero_mask),
        .bcast     (bcast),
        .src2_mem  (src2_mem),
        .ctrl      (ctrl)
    );

    simd_or_bcast u_bc (
        .ctrl     (ctrl),
        .src2     (src2),
        .src2_eff (src2_eff)
    );

    assign opa = ctrl.a_is_dst ? dst_old : src1;

    simd_or_lanes u_lanes (
        .ctrl    (ctrl),
        .opa     (opa),
        .opb     (src2_eff),
        .dst_old (dst_old),
        .kmask   (kmask),
        .res     (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            err       <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            err       <= in_valid && !ctrl.legal;
            if (in_valid)
                result <= res_c;
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R11
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> out_valid);

    // R11
    err_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && mode[2] |=> err && (result == $past(dst_old)));

    // R8
    above_vl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && mode == OP_MASKED && vlen == 2'd0 |=> result[MAXW-1:128] == '0);

    // R1
    scalar_upper_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && mode == OP_SCALAR64 |=> result[MAXW-1:64] == $past(dst_old[MAXW-1:64]));

endmodule

// File: tb/tb_simd_or_unit.sv
module tb_simd_or_unit;
    localparam int W = 512;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [2:0]    mode;
    logic [1:0]    vlen;
    logic          esz64;
    logic [W-1:0]  src1, src2, dst_old;
    logic [15:0]   kmask;
    logic          mask_en, zero_mask, bcast, src2_mem;
    logic          out_valid;
    logic [W-1:0]  result;
    logic          err;

    typedef struct {
        logic [W-1:0] r;
        logic         e;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    always #10 clk = ~clk;

    simd_or_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .vlen(vlen),
        .esz64(esz64), .src1(src1), .src2(src2), .dst_old(dst_old), .kmask(kmask),
        .mask_en(mask_en), .zero_mask(zero_mask), .bcast(bcast), .src2_mem(src2_mem),
        .out_valid(out_valid), .result(result), .err(err)
    );

    function automatic logic [W-1:0] rnd512();
        logic [W-1:0] v;
        for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Bit-level model written from the requirements.
    function automatic void model(input logic [2:0] m, input logic [1:0] v, input logic es,
                                  input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [W-1:0] o, input logic [15:0] k,
                                  input logic men, input logic zm, input logic bc,
                                  input logic mem, output logic [W-1:0] r, output logic e);
        int bits, ew;
        r = o;
        e = 1'b0;
        case (m)
            3'd0: for (int i = 0; i < 64; i++) r[i] = o[i] | b[i];
            3'd1: for (int i = 0; i < 128; i++) r[i] = o[i] | b[i];
            3'd2: begin
                if (v > 2'd1) e = 1'b1;
                else begin
                    bits = (v == 2'd0) ? 128 : 256;
                    for (int i = 0; i < W; i++) r[i] = (i < bits) ? (a[i] | b[i]) : 1'b0;
                end
            end
            3'd3: begin
                if (v == 2'd3) e = 1'b1;
                else begin
                    bits = 128 << v;
                    ew   = es ? 64 : 32;
                    for (int i = 0; i < W; i++) begin
                        if (i >= bits) r[i] = 1'b0;
                        else if (!men || k[i / ew])
                            r[i] = a[i] | b[(bc && mem) ? (i % ew) : i];
                        else
                            r[i] = zm ? 1'b0 : o[i];
                    end
                end
            end
            default: e = 1'b1;
        endcase
    endfunction

    task automatic send(input logic [2:0] m, input logic [1:0] v, input logic es,
                        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] o,
                        input logic [15:0] k, input logic men, input logic zm,
                        input logic bc, input logic mem, input string tag);
        exp_t x;
        @(negedge clk);
        in_valid = 1'b1; mode = m; vlen = v; esz64 = es;
        src1 = a; src2 = b; dst_old = o; kmask = k;
        mask_en = men; zero_mask = zm; bcast = bc; src2_mem = mem;
        model(m, v, es, a, b, o, k, men, zm, bc, mem, x.r, x.e);
        x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compares each produced result against the queued expectation.
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10: out_valid=1 with nothing outstanding");
                end else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    checks++;
                    if (result !== x.r || err !== x.e) begin
                        errors++;
                        $display("FAIL %s: result=%h err=%b expected result=%h err=%b",
                                 x.tag, result, err, x.r, x.e);
                    end
                end
            end else if (exp_q.size() != 0) begin
                checks++; errors++;
                $display("FAIL R10: out_valid=0 actual, 1 expected (%s)", exp_q[0].tag);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a, b, o, ones;
        ones = '1;
        rst = 1'b1; in_valid = 1'b0; mode = '0; vlen = '0; esz64 = 1'b0;
        src1 = '0; src2 = '0; dst_old = '0; kmask = '0;
        mask_en = 1'b0; zero_mask = 1'b0; bcast = 1'b0; src2_mem = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || err !== 1'b0) begin
            errors++;
            $display("FAIL R10: reset out_valid=%b err=%b expected 0 0", out_valid, err);
        end
        rst = 1'b0;

        a = rnd512(); b = rnd512(); o = rnd512();
        send(3'd0, 2'd0, 1'b0, a, b, o, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 scalar");
        send(3'd0, 2'd3, 1'b0, '0, '0, '0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 zeros");
        send(3'd1, 2'd0, 1'b0, a, b, o, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 legacy");
        send(3'd2, 2'd0, 1'b0, a, b, ones, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 zeroup 128");
        send(3'd2, 2'd1, 1'b0, a, b, ones, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 zeroup 256");
        idle();
        send(3'd3, 2'd2, 1'b0, a, b, o, 16'hA5C3, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R5 merge 32b");
        send(3'd3, 2'd2, 1'b0, a, b, o, 16'hA5C3, 1'b1, 1'b1, 1'b0, 1'b0, "R5 zeroing 32b");
        send(3'd3, 2'd2, 1'b1, a, b, o, 16'h0096, 1'b1, 1'b0, 1'b0, 1'b0, "R4 merge 64b");
        send(3'd3, 2'd1, 1'b1, a, b, o, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, "R4 mask off");
        send(3'd3, 2'd0, 1'b0, a, b, ones, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R8 above vl");
        send(3'd3, 2'd1, 1'b0, a, b, ones, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R8 full mask");
        send(3'd3, 2'd2, 1'b0, a, b, o, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, "R6 bcast 32b");
        send(3'd3, 2'd2, 1'b1, a, b, o, 16'h00FF, 1'b1, 1'b0, 1'b1, 1'b1, "R6 bcast 64b");
        send(3'd3, 2'd2, 1'b0, a, b, o, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, "R7 bcast reg");
        send(3'd3, 2'd0, 1'b1, a, b, o, 16'hFFF1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 high mask bits");
        send(3'd3, 2'd1, 1'b0, a, b, o, 16'hFF00, 1'b1, 1'b1, 1'b0, 1'b0, "R9 beyond 8 elems");
        send(3'd5, 2'd0, 1'b0, a, b, o, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 mode 5");
        send(3'd3, 2'd3, 1'b0, a, b, o, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R11 masked vlen 3");
        send(3'd2, 2'd2, 1'b0, a, b, o, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 zeroup vlen 2");
        send(3'd0, 2'd0, 1'b0, a, b, o, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 err clears");
        idle(); idle();

        for (int n = 0; n < 300; n++) begin
            logic [2:0] m;
            m = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(4, 7));
            send(m, 2'($urandom_range(0, 3)), 1'($urandom), rnd512(), rnd512(), rnd512(),
                 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 "R4 R5 R6 R11 random");
            if ($urandom_range(0, 3) == 0) idle();
        end
        idle(); idle();

        // R10: an input presented during reset yields no valid output.
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b0 || err !== 1'b0) begin
            errors++;
            $display("FAIL R10: after reset out_valid=%b err=%b expected 0 0", out_valid, err);
        end
        rst = 1'b0;
        idle(); idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: %0d results outstanding, expected 0", exp_q.size());
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule